// File: doc/BRIEF.md
# Execution-Location Peripheral Guard

This block watches the instruction-fetch side of a processor and keeps one permission flag for a protected serial peripheral controller. The flag is set when the processor fetches an instruction from a single fixed entry address. It is cleared as soon as the processor fetches an instruction from anywhere inside the RAM window. Fetches from any other address leave the flag as it is. So only code that has entered through the fixed entry point and has not yet run from RAM can drive the peripheral.

The block also decodes a small memory-mapped register window. While the flag is set, writes reach the peripheral's control inputs (enable, start, transmit byte) and reads return the peripheral's real state. While the flag is clear, protected writes are dropped and protected reads return zero. Every access still completes with a ready pulse. A status word showing the flag can always be read. A reset-request register raises a one-cycle pulse toward the system reset generator whatever the flag's state. The serial pins themselves are not gated. Only the controller's inputs are.

Top module: `fetch_access_guard`

## Requirements
- R1: After reset, accessOk, spiEnable, spiStart, sysResetReq are 0 and spiTxData is 0.
- R2: A fetch with fetchValid high at address TRAMP_ADDR (default 32'h0000_1000) sets accessOk on the next clock edge.
- R3: A fetch with fetchValid high at an address in [RAM_BASE, RAM_BASE+RAM_SIZE) (default 32'h4000_0000, size 32'h0002_0000), including the last word, clears accessOk on the next clock edge.
- R4: A fetch at any other address, or any address while fetchValid is low, leaves accessOk unchanged; 32'h4002_0000 is outside RAM.
- R5: While accessOk is 1, a write to offset 1 sets spiEnable from wdata bit 0, a write to offset 3 sets spiTxData from wdata[7:0], and a write to offset 2 makes spiStart high for exactly the one cycle after the write.
- R6: While accessOk is 0, writes to offsets 1, 2 and 3 are dropped: spiEnable and spiTxData keep their values and spiStart stays 0.
- R7: Every access with busCs high gives busReady high in the next cycle with busRdata valid then; granted reads return offset 1 = {31'b0,spiEnable}, offset 3 = spiTxData, offset 4 = periphRxData, offset 5 = {31'b0,periphBusy}, other unmapped offsets 0.
- R8: While accessOk is 0, reads of offsets 1, 3, 4 and 5 return 32'h0.
- R9: A read of offset 0 returns {31'b0,accessOk} whatever the permission state.
- R10: A write to offset 15 raises sysResetReq for exactly the next cycle, whether or not access is granted.
- R11: Bus access is judged by the registered flag: a protected write issued in the same cycle as the granting fetch is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| fetchValid | input | 1 | Instruction fetch in progress |
| fetchAddr | input | 32 | Instruction fetch address |
| busCs | input | 1 | Register access strobe |
| busWe | input | 1 | 1 = write, 0 = read |
| busAddr | input | 8 | Register word offset |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data, valid with busReady |
| busReady | output | 1 | Access completion pulse |
| periphRxData | input | 8 | Received byte from the serial controller |
| periphBusy | input | 1 | Busy indication from the serial controller |
| spiEnable | output | 1 | Gated enable toward the serial controller |
| spiStart | output | 1 | Gated one-cycle start pulse |
| spiTxData | output | 8 | Gated transmit byte |
| sysResetReq | output | 1 | System reset request pulse |
| accessOk | output | 1 | Current permission flag |

## Verification
The hardest case to reach is a bus write in the very cycle that the granting fetch arrives. There the flag is still clear and the write must be lost. The stimulus drives fetchValid at the entry address and a transmit-byte write on the same falling edge, then reads the port back once the grant is visible. The last RAM word and the first word past RAM are also fetched back to back, each from a granted state, to pin down the window edges.

// File: rtl/guard_pkg.sv
package guard_pkg;
  localparam int OFS_STATUS = 0;
  localparam int OFS_CTRL   = 1;
  localparam int OFS_START  = 2;
  localparam int OFS_TX     = 3;
  localparam int OFS_RX     = 4;
  localparam int OFS_BUSY   = 5;
  localparam int OFS_RESET  = 15;

  typedef enum logic [2:0] {
    RD_NONE, RD_STATUS, RD_CTRL, RD_TX, RD_RX, RD_BUSY
  } rdSel_e;

  typedef struct packed {
    logic   wrEnable;
    logic   wrStart;
    logic   wrTx;
    logic   wrReset;
    logic   ack;
    rdSel_e rdSel;
  } strobes_t;
endpackage

// File: rtl/guard_ctrl.sv
module guard_ctrl
  import guard_pkg::*;
#(
  parameter int          FA_W       = 32,
  parameter int          BA_W       = 8,
  parameter logic [31:0] TRAMP_ADDR = 32'h0000_1000,
  parameter logic [31:0] RAM_BASE   = 32'h4000_0000,
  parameter logic [31:0] RAM_SIZE   = 32'h0002_0000
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            fetchValid,
  input  logic [FA_W-1:0] fetchAddr,
  input  logic            busCs,
  input  logic            busWe,
  input  logic [BA_W-1:0] busAddr,
  output logic            accessOk,
  output strobes_t        strb
);
  localparam logic [FA_W-1:0] TRAMP = FA_W'(TRAMP_ADDR);
  localparam logic [FA_W-1:0] RBASE = FA_W'(RAM_BASE);
  localparam logic [FA_W-1:0] RSIZE = FA_W'(RAM_SIZE);

  logic hitTramp, hitRam, okReg;

  always_comb begin
    hitTramp = fetchValid && (fetchAddr == TRAMP);
    hitRam   = fetchValid && (fetchAddr >= RBASE) && ((fetchAddr - RBASE) < RSIZE);
  end

  // Entry address wins if it ever falls inside RAM.
  always_ff @(posedge clk) begin
    if (!rstN)         okReg <= 1'b0;
    else if (hitTramp) okReg <= 1'b1;
    else if (hitRam)   okReg <= 1'b0;
  end

  assign accessOk = okReg;

  always_comb begin
    logic wr, rd;
    wr = busCs && busWe;
    rd = busCs && !busWe;
    strb          = '0;
    strb.ack      = busCs;
    strb.rdSel    = RD_NONE;
    strb.wrEnable = wr && okReg && (busAddr == BA_W'(OFS_CTRL));
    strb.wrStart  = wr && okReg && (busAddr == BA_W'(OFS_START));
    strb.wrTx     = wr && okReg && (busAddr == BA_W'(OFS_TX));
    strb.wrReset  = wr && (busAddr == BA_W'(OFS_RESET));
    if (rd) begin
      if (busAddr == BA_W'(OFS_STATUS)) strb.rdSel = RD_STATUS;
      else if (okReg) begin
        case (busAddr)
          BA_W'(OFS_CTRL): strb.rdSel = RD_CTRL;
          BA_W'(OFS_TX):   strb.rdSel = RD_TX;
          BA_W'(OFS_RX):   strb.rdSel = RD_RX;
          BA_W'(OFS_BUSY): strb.rdSel = RD_BUSY;
          default:         strb.rdSel = RD_NONE;
        endcase
      end
    end
  end
endmodule

// File: rtl/guard_dp.sv
module guard_dp
  import guard_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int TX_W   = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobes_t          strb,
  input  logic              accessOk,
  input  logic [DATA_W-1:0] busWdata,
  input  logic [TX_W-1:0]   periphRxData,
  input  logic              periphBusy,
  output logic [DATA_W-1:0] busRdata,
  output logic              busReady,
  output logic              spiEnable,
  output logic              spiStart,
  output logic [TX_W-1:0]   spiTxData,
  output logic              sysResetReq
);
  logic [DATA_W-1:0] rdNext;

  always_comb begin
    case (strb.rdSel)
      RD_STATUS: rdNext = DATA_W'(accessOk);
      RD_CTRL:   rdNext = DATA_W'(spiEnable);
      RD_TX:     rdNext = DATA_W'(spiTxData);
      RD_RX:     rdNext = DATA_W'(periphRxData);
      RD_BUSY:   rdNext = DATA_W'(periphBusy);
      default:   rdNext = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      spiEnable   <= 1'b0;
      spiTxData   <= '0;
      spiStart    <= 1'b0;
      sysResetReq <= 1'b0;
      busReady    <= 1'b0;
      busRdata    <= '0;
    end else begin
      if (strb.wrEnable) spiEnable <= busWdata[0];
      if (strb.wrTx)     spiTxData <= busWdata[TX_W-1:0];
      spiStart    <= strb.wrStart;
      sysResetReq <= strb.wrReset;
      busReady    <= strb.ack;
      busRdata    <= strb.ack ? rdNext : '0;
    end
  end
endmodule

// File: rtl/fetch_access_guard.sv
module fetch_access_guard
  import guard_pkg::*;
#(
  parameter int          FA_W       = 32,
  parameter int          BA_W       = 8,
  parameter int          DATA_W     = 32,
  parameter int          TX_W       = 8,
  parameter logic [31:0] TRAMP_ADDR = 32'h0000_1000,
  parameter logic [31:0] RAM_BASE   = 32'h4000_0000,
  parameter logic [31:0] RAM_SIZE   = 32'h0002_0000
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              fetchValid,
  input  logic [FA_W-1:0]   fetchAddr,
  input  logic              busCs,
  input  logic              busWe,
  input  logic [BA_W-1:0]   busAddr,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] busRdata,
  output logic              busReady,
  input  logic [TX_W-1:0]   periphRxData,
  input  logic              periphBusy,
  output logic              spiEnable,
  output logic              spiStart,
  output logic [TX_W-1:0]   spiTxData,
  output logic              sysResetReq,
  output logic              accessOk
);
  strobes_t strb;

  guard_ctrl #(
    .FA_W(FA_W), .BA_W(BA_W), .TRAMP_ADDR(TRAMP_ADDR),
    .RAM_BASE(RAM_BASE), .RAM_SIZE(RAM_SIZE)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .fetchValid(fetchValid), .fetchAddr(fetchAddr),
    .busCs(busCs), .busWe(busWe), .busAddr(busAddr),
    .accessOk(accessOk), .strb(strb)
  );

  guard_dp #(.DATA_W(DATA_W), .TX_W(TX_W)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .accessOk(accessOk),
    .busWdata(busWdata), .periphRxData(periphRxData), .periphBusy(periphBusy),
    .busRdata(busRdata), .busReady(busReady), .spiEnable(spiEnable),
    .spiStart(spiStart), .spiTxData(spiTxData), .sysResetReq(sysResetReq)
  );
endmodule

// File: rtl/guard_checker.sv
module guard_checker #(
  parameter int          FA_W       = 32,
  parameter int          BA_W       = 8,
  parameter int          DATA_W     = 32,
  parameter int          TX_W       = 8,
  parameter logic [31:0] TRAMP_ADDR = 32'h0000_1000,
  parameter logic [31:0] RAM_BASE   = 32'h4000_0000,
  parameter logic [31:0] RAM_SIZE   = 32'h0002_0000
) (
  input logic              clk,
  input logic              rstN,
  input logic              fetchValid,
  input logic [FA_W-1:0]   fetchAddr,
  input logic              busCs,
  input logic              busWe,
  input logic [BA_W-1:0]   busAddr,
  input logic [DATA_W-1:0] busRdata,
  input logic              busReady,
  input logic              spiEnable,
  input logic              spiStart,
  input logic [TX_W-1:0]   spiTxData,
  input logic              sysResetReq,
  input logic              accessOk
);
  logic isTramp, isRam;
  assign isTramp = fetchValid && (fetchAddr == FA_W'(TRAMP_ADDR));
  assign isRam   = fetchValid && (fetchAddr >= FA_W'(RAM_BASE))
                   && ((fetchAddr - FA_W'(RAM_BASE)) < FA_W'(RAM_SIZE));

  AST_GRANT_ON_ENTRY: assert property (@(posedge clk) disable iff (!rstN)
    isTramp |=> accessOk); // R2
  AST_REVOKE_IN_RAM: assert property (@(posedge clk) disable iff (!rstN)
    (isRam && !isTramp) |=> !accessOk); // R3
  AST_HOLD_ELSEWHERE: assert property (@(posedge clk) disable iff (!rstN)
    !(isRam || isTramp) |=> $stable(accessOk)); // R4
  AST_NO_START_DENIED: assert property (@(posedge clk) disable iff (!rstN)
    !accessOk |=> !spiStart); // R6
  AST_KEEP_CTRL_DENIED: assert property (@(posedge clk) disable iff (!rstN)
    !accessOk |=> ($stable(spiEnable) && $stable(spiTxData))); // R6
  AST_READY_FOLLOWS: assert property (@(posedge clk) disable iff (!rstN)
    busCs |=> busReady); // R7
  AST_NO_SPURIOUS_READY: assert property (@(posedge clk) disable iff (!rstN)
    !busCs |=> !busReady); // R7
  AST_ZERO_DENIED_READ: assert property (@(posedge clk) disable iff (!rstN)
    (busCs && !busWe && !accessOk && busAddr != '0) |=> (busRdata == '0)); // R8
  AST_RESET_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    (busCs && busWe && busAddr == BA_W'(15)) |=> sysResetReq); // R10
endmodule

bind fetch_access_guard guard_checker #(
  .FA_W(FA_W), .BA_W(BA_W), .DATA_W(DATA_W), .TX_W(TX_W),
  .TRAMP_ADDR(TRAMP_ADDR), .RAM_BASE(RAM_BASE), .RAM_SIZE(RAM_SIZE)
) u_chk (
  .clk(clk), .rstN(rstN), .fetchValid(fetchValid), .fetchAddr(fetchAddr),
  .busCs(busCs), .busWe(busWe), .busAddr(busAddr), .busRdata(busRdata),
  .busReady(busReady), .spiEnable(spiEnable), .spiStart(spiStart),
  .spiTxData(spiTxData), .sysResetReq(sysResetReq), .accessOk(accessOk)
);

// File: tb/sim_fetch_access_guard.sv
module sim_fetch_access_guard;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        fetchValid = 1'b0;
  logic [31:0] fetchAddr = '0;
  logic        busCs = 1'b0, busWe = 1'b0;
  logic [7:0]  busAddr = '0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic        busReady;
  logic [7:0]  periphRxData = 8'hA5;
  logic        periphBusy = 1'b1;
  logic        spiEnable, spiStart, sysResetReq, accessOk;
  logic [7:0]  spiTxData;

  int total = 0, bad = 0;

  typedef struct { bit isRead; logic [31:0] data; string req; } item_t;
  item_t sb[$];

  always #5 clk = ~clk;

  fetch_access_guard u0 (
    .clk(clk), .rstN(rstN), .fetchValid(fetchValid), .fetchAddr(fetchAddr),
    .busCs(busCs), .busWe(busWe), .busAddr(busAddr), .busWdata(busWdata),
    .busRdata(busRdata), .busReady(busReady), .periphRxData(periphRxData),
    .periphBusy(periphBusy), .spiEnable(spiEnable), .spiStart(spiStart),
    .spiTxData(spiTxData), .sysResetReq(sysResetReq), .accessOk(accessOk)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Monitor: every ready pulse pops one expected item.
  always @(negedge clk) begin
    if (rstN && busReady) begin
      if (sb.size() == 0) check(1'b0, "R7", 32'd1, 32'd0);
      else begin
        item_t it;
        it = sb.pop_front();
        if (it.isRead) check(busRdata === it.data, it.req, busRdata, it.data);
      end
    end
  end

  task automatic fetch(input logic [31:0] a, input bit v = 1'b1);
    @(negedge clk); fetchValid = v; fetchAddr = a;
    @(negedge clk); fetchValid = 1'b0;
  endtask

  task automatic busWrite(input logic [7:0] a, input logic [31:0] d);
    item_t it;
    @(negedge clk);
    it.isRead = 1'b0; it.data = '0; it.req = "R7"; sb.push_back(it);
    busCs = 1'b1; busWe = 1'b1; busAddr = a; busWdata = d;
    @(negedge clk); busCs = 1'b0; busWe = 1'b0;
  endtask

  task automatic busRead(input logic [7:0] a, input logic [31:0] exp, input string req);
    item_t it;
    @(negedge clk);
    it.isRead = 1'b1; it.data = exp; it.req = req; sb.push_back(it);
    busCs = 1'b1; busWe = 1'b0; busAddr = a;
    @(negedge clk); busCs = 1'b0;
  endtask

  initial begin
    #1_000_000;
    check(1'b0, "watchdog", 32'd0, 32'd1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(accessOk == 0 && spiEnable == 0 && spiStart == 0 && sysResetReq == 0, "R1",
          {accessOk, spiEnable, spiStart, sysResetReq}, 32'd0);
    check(spiTxData == 8'h00, "R1", spiTxData, 32'h0);

    busRead(8'd0, 32'd0, "R9");
    busRead(8'd1, 32'd0, "R8");
    busRead(8'd4, 32'd0, "R8");
    busRead(8'd5, 32'd0, "R8");

    // R6 denied writes
    busWrite(8'd1, 32'd1);
    check(spiEnable == 1'b0, "R6", spiEnable, 32'd0);
    busWrite(8'd2, 32'd1);
    check(spiStart == 1'b0, "R6", spiStart, 32'd0);
    busWrite(8'd3, 32'h3C);
    check(spiTxData == 8'h00, "R6", spiTxData, 32'h0);

    // R4 other addresses / invalid fetch
    fetch(32'h0000_0200);
    check(accessOk == 1'b0, "R4", accessOk, 32'd0);
    fetch(32'h0000_1000, 1'b0);
    check(accessOk == 1'b0, "R4", accessOk, 32'd0);

    // R2 grant
    fetch(32'h0000_1000);
    check(accessOk == 1'b1, "R2", accessOk, 32'd1);
    fetch(32'h0000_0300);
    check(accessOk == 1'b1, "R4", accessOk, 32'd1);

    // R5 granted writes
    busWrite(8'd1, 32'hFFFF_FFF1);
    check(spiEnable == 1'b1, "R5", spiEnable, 32'd1);
    busWrite(8'd3, 32'h0000_015A);
    check(spiTxData == 8'h5A, "R5", spiTxData, 32'h5A);
    busWrite(8'd2, 32'd0);
    check(spiStart == 1'b1, "R5", spiStart, 32'd1);
    @(negedge clk);
    check(spiStart == 1'b0, "R5", spiStart, 32'd0);

    // R7 / R9 granted reads
    busRead(8'd0, 32'd1, "R9");
    busRead(8'd1, 32'd1, "R7");
    busRead(8'd3, 32'h5A, "R7");
    busRead(8'd4, 32'hA5, "R7");
    busRead(8'd5, 32'd1, "R7");
    busRead(8'd9, 32'd0, "R7");

    // R3 revoke, RAM boundary
    fetch(32'h4000_0010);
    check(accessOk == 1'b0, "R3", accessOk, 32'd0);
    fetch(32'h0000_1000);
    fetch(32'h4002_0000);
    check(accessOk == 1'b1, "R4", accessOk, 32'd1);
    fetch(32'h4001_FFFC);
    check(accessOk == 1'b0, "R3", accessOk, 32'd0);

    // denied again: state stays, reads zero
    busRead(8'd3, 32'd0, "R8");
    busRead(8'd1, 32'd0, "R8");
    busWrite(8'd1, 32'd0);
    check(spiEnable == 1'b1, "R6", spiEnable, 32'd1);

    // R10 reset request while denied
    busWrite(8'd15, 32'd0);
    check(sysResetReq == 1'b1, "R10", sysResetReq, 32'd1);
    @(negedge clk);
    check(sysResetReq == 1'b0, "R10", sysResetReq, 32'd0);

    // R11 write together with granting fetch is dropped
    begin
      item_t it;
      @(negedge clk);
      it.isRead = 1'b0; it.data = '0; it.req = "R11"; sb.push_back(it);
      fetchValid = 1'b1; fetchAddr = 32'h0000_1000;
      busCs = 1'b1; busWe = 1'b1; busAddr = 8'd3; busWdata = 32'h77;
      @(negedge clk);
      fetchValid = 1'b0; busCs = 1'b0; busWe = 1'b0;
    end
    check(accessOk == 1'b1, "R11", accessOk, 32'd1);
    check(spiTxData == 8'h5A, "R11", spiTxData, 32'h5A);
    busRead(8'd3, 32'h5A, "R11");

    repeat (3) @(negedge clk);
    check(sb.size() == 0, "R7", sb.size(), 32'd0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule